// File: doc/BRIEF.md
# Audio Sample-Rate Detector

This block times an incoming audio word-select line against a free-running reference clock. It decides which of nine standard audio sample rates the line carries. Each measurement counts reference cycles across a fixed number of word-select periods. The count is compared with nine acceptance windows that are worked out at elaboration from the reference-frequency parameter and a parts-per-million tolerance. A rate is declared locked only when two back-to-back measurements agree. An error flag reports timing that matches no rate, and a silence timer drops the lock when the line stops.

Two mode pins select the operating mode. Three pin values give a standard mode, in which a small rate register belongs to software and the pins also give the bus subaddress. The fourth value gives a decoder-companion mode. In that mode the register is slaved to the detector and software writes have no effect. After reset the register holds a wide-band value, which covers the 32 to 48 kHz band with no write needed. Rates below that band need software to load a setting.

Top module: `srd_rate_detector`

## Requirements
- R1: Rate codes follow ascending frequency: 0=8 kHz, 1=11.025 kHz, 2=12 kHz, 3=16 kHz, 4=22.05 kHz, 5=24 kHz, 6=32 kHz, 7=44.1 kHz, 8=48 kHz. One measurement is the number of reference cycles between a word-select rising edge and the rising edge 2^AVG_LOG2 periods later. Measurements follow one another without a gap.
- R2: A measurement matches a rate when it differs from that rate's nominal count, round(REF_HZ·2^AVG_LOG2/fs), by no more than floor(nominal·PPM_TOL/10^6). PPM_TOL defaults to 200.
- R3: `rate_valid` rises only when a matching measurement carries the same code as the measurement just before it, and that measurement also matched. `rate_code` takes the new code at that point.
- R4: A measurement that matches no rate sets `rate_err` and clears `rate_valid`, and `rate_code` keeps its value. The next measurement that does match clears `rate_err`.
- R5: A matching measurement whose code differs from the previous measurement clears `rate_valid`, keeps `rate_code` and clears `rate_err`.
- R6: If no rising edge arrives for TO_LIM = 2·ceil(REF_HZ/8000) reference cycles, `rate_valid` clears and `rate_code` is held. Counting restarts at the next rising edge, so two fresh measurements are needed before lock returns.
- R7: `bus_subaddr` equals the mode-pin value. Pin value 3 selects the decoder-companion mode with subaddress 3. Values 0, 1 and 2 select standard mode.
- R8: In standard mode a write loads `reg_wr_data` into `rate_reg` on the next cycle. Detection never changes `rate_reg` in this mode.
- R9: In decoder-companion mode `rate_reg` copies `rate_code` one cycle later and writes are ignored. On a return to standard mode, `rate_reg` keeps the last copied code.
- R10: After reset `rate_code`=0, `rate_valid`=0, `rate_err`=0 and `rate_reg`=15, which is the wide-band default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_in | input | 1 | Asynchronous word-select line |
| mode_pins | input | 2 | Mode and subaddress pins |
| reg_wr_en | input | 1 | Software write strobe for the rate register |
| reg_wr_data | input | 4 | Software rate value |
| rate_code | output | 4 | Last confirmed rate code |
| rate_valid | output | 1 | Lock flag |
| rate_err | output | 1 | Last measurement matched no rate |
| rate_reg | output | 4 | Effective rate register |
| bus_subaddr | output | 2 | Selected bus subaddress |

## Verification
The hardest situation to reach is a measurement that lands just inside or just outside a tolerance window. The window is only about one count wide, so the stimulus has to control the total count of a measurement to the exact cycle. The bench sets the reference-frequency parameter so that every nominal period is a whole number of clock cycles, and it drives word-select in step with the clock. It first forces a silence timeout so that measurement boundaries line up with the edges it generates. It then stretches or shrinks one period per measurement by one cycle, about 142 ppm, or by two cycles, about 283 ppm.

// File: rtl/srd_pkg.sv
package srd_pkg;

    localparam int NUM_RATES  = 9;
    localparam int CODE_W     = 4;
    localparam int SLOWEST_HZ = 8000;
    localparam logic [CODE_W-1:0] REG_WIDEBAND = 4'hF;
    localparam logic [1:0]        PINS_MPEG    = 2'b11;

    typedef logic [CODE_W-1:0] rate_code_t;

    typedef enum logic {
        MODE_STANDARD = 1'b0,
        MODE_MPEG     = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic       hit;
        rate_code_t code;
    } class_res_t;

    typedef struct packed {
        logic       valid;
        logic       err;
        rate_code_t code;
    } lock_state_t;

    // Frequency in Hz for each code, ascending.
    function automatic longint rate_hz(input int idx);
        case (idx)
            0:       return 64'd8000;
            1:       return 64'd11025;
            2:       return 64'd12000;
            3:       return 64'd16000;
            4:       return 64'd22050;
            5:       return 64'd24000;
            6:       return 64'd32000;
            7:       return 64'd44100;
            default: return 64'd48000;
        endcase
    endfunction

    // Rounded reference-cycle count over 2^avg_log2 periods.
    function automatic longint nominal_count(input longint ref_hz, input int avg_log2, input int idx);
        longint fs;
        fs = rate_hz(idx);
        return ((ref_hz << avg_log2) * 2 + fs) / (2 * fs);
    endfunction

    function automatic longint half_window(input longint nominal, input int ppm);
        return (nominal * ppm) / 1_000_000;
    endfunction

    function automatic op_mode_e decode_mode(input logic [1:0] pins);
        return (pins == PINS_MPEG) ? MODE_MPEG : MODE_STANDARD;
    endfunction

endpackage

// File: rtl/srd_period_meter.sv
module srd_period_meter #(
    parameter int AVG_LOG2 = 10,
    parameter int TO_LIM   = 3682,
    parameter int ACC_W    = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ws_in,
    output logic             meas_stb,
    output logic [ACC_W-1:0] meas_cnt,
    output logic             timeout_stb
);
    localparam int NPER = 1 << AVG_LOG2;
    localparam int NP_W = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;
    localparam int TO_W = $clog2(TO_LIM + 1);

    logic [1:0]       sync_q;
    logic             prev_q;
    logic             rise;
    logic             running_q;
    logic [NP_W-1:0]  np_q;
    logic [ACC_W-1:0] acc_q;
    logic [TO_W-1:0]  idle_q;
    logic             last_period;

    assign rise        = sync_q[1] & ~prev_q;
    assign last_period = (np_q == NP_W'(NPER - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q      <= '0;
            prev_q      <= 1'b0;
            running_q   <= 1'b0;
            np_q        <= '0;
            acc_q       <= '0;
            idle_q      <= '0;
            meas_stb    <= 1'b0;
            meas_cnt    <= '0;
            timeout_stb <= 1'b0;
        end else begin
            sync_q      <= {sync_q[0], ws_in};
            prev_q      <= sync_q[1];
            meas_stb    <= 1'b0;
            timeout_stb <= 1'b0;
            if (rise) begin
                idle_q    <= '0;
                running_q <= 1'b1;
                if (running_q && last_period) begin
                    meas_stb <= 1'b1;
                    meas_cnt <= acc_q + ACC_W'(1);
                end
                if (!running_q || last_period) begin
                    np_q  <= '0;
                    acc_q <= '0;
                end else begin
                    np_q  <= np_q + NP_W'(1);
                    acc_q <= acc_q + ACC_W'(1);
                end
            end else begin
                if (running_q) acc_q <= acc_q + ACC_W'(1);
                if (idle_q != TO_W'(TO_LIM)) begin
                    idle_q <= idle_q + TO_W'(1);
                    if (idle_q == TO_W'(TO_LIM - 1)) begin
                        timeout_stb <= 1'b1;
                        running_q   <= 1'b0;
                    end
                end
            end
        end
    end

    // R6: a silence timeout restarts counting, so no measurement can follow at once
    p_silence_no_meas_r6: assert property (@(posedge clk) disable iff (rst)
        timeout_stb |=> !meas_stb)
        else $error("measurement completed right after timeout");

endmodule

// File: rtl/srd_rate_classifier.sv
module srd_rate_classifier
    import srd_pkg::*;
#(
    parameter int REF_HZ   = 14_725_000,
    parameter int AVG_LOG2 = 10,
    parameter int PPM_TOL  = 200,
    parameter int ACC_W    = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] meas_cnt,
    output class_res_t       result
);
    logic [NUM_RATES-1:0] hit_vec;

    for (genvar i = 0; i < NUM_RATES; i++) begin : g_win
        localparam longint NOM  = nominal_count(longint'(REF_HZ), AVG_LOG2, i);
        localparam longint HALF = half_window(NOM, PPM_TOL);
        localparam logic [ACC_W-1:0] LO = ACC_W'(NOM - HALF);
        localparam logic [ACC_W-1:0] HI = ACC_W'(NOM + HALF);
        assign hit_vec[i] = (meas_cnt >= LO) && (meas_cnt <= HI);
    end

    always_comb begin
        result.hit  = |hit_vec;
        result.code = '0;
        for (int k = 0; k < NUM_RATES; k++) begin
            if (hit_vec[k]) result.code = CODE_W'(k);
        end
    end

    // R2: tolerance windows never overlap
    p_single_window_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec))
        else $error("count falls in more than one window");

endmodule

// File: rtl/srd_lock_tracker.sv
module srd_lock_tracker
    import srd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        meas_stb,
    input  class_res_t  cls,
    input  logic        timeout_stb,
    output lock_state_t state
);
    lock_state_t st_q;
    logic        prev_ok_q;
    rate_code_t  prev_code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '{valid: 1'b0, err: 1'b0, code: '0};
            prev_ok_q   <= 1'b0;
            prev_code_q <= '0;
        end else if (meas_stb) begin
            if (!cls.hit) begin
                st_q.err   <= 1'b1;
                st_q.valid <= 1'b0;
                prev_ok_q  <= 1'b0;
            end else begin
                st_q.err    <= 1'b0;
                prev_ok_q   <= 1'b1;
                prev_code_q <= cls.code;
                if (prev_ok_q && (prev_code_q == cls.code)) begin
                    st_q.valid <= 1'b1;
                    st_q.code  <= cls.code;
                end else begin
                    st_q.valid <= 1'b0;
                end
            end
        end else if (timeout_stb) begin
            st_q.valid <= 1'b0;
            prev_ok_q  <= 1'b0;
        end
    end

    assign state = st_q;

    // R3: lock only rises on an in-window measurement
    p_valid_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(state.valid) |-> ($past(meas_stb) && $past(cls.hit)))
        else $error("valid rose without a matching measurement");

    // R4: error only rises on an out-of-window measurement, and the code is kept
    p_err_rise_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(state.err) |-> ($past(meas_stb) && !$past(cls.hit)))
        else $error("error rose without a failed measurement");

    p_code_held_r4: assert property (@(posedge clk) disable iff (rst)
        (meas_stb && !cls.hit) |=> $stable(state.code))
        else $error("code changed on a failed measurement");

    // R6: a timeout leaves no lock behind
    p_timeout_clears_r6: assert property (@(posedge clk) disable iff (rst)
        timeout_stb |=> !state.valid)
        else $error("valid survived a timeout");

    // R1: a locked code is one of the nine rates
    p_code_range_r1: assert property (@(posedge clk) disable iff (rst)
        state.valid |-> (state.code < CODE_W'(NUM_RATES)))
        else $error("locked code out of range");

endmodule

// File: rtl/srd_rate_register.sv
module srd_rate_register
    import srd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pins,
    input  logic       wr_en,
    input  rate_code_t wr_data,
    input  rate_code_t det_code,
    output rate_code_t rate_reg,
    output logic [1:0] subaddr
);
    op_mode_e   mode;
    rate_code_t reg_q;

    assign mode = decode_mode(mode_pins);

    always_ff @(posedge clk) begin
        if (rst)                     reg_q <= REG_WIDEBAND;
        else if (mode == MODE_MPEG)  reg_q <= det_code;
        else if (wr_en)              reg_q <= wr_data;
    end

    assign rate_reg = reg_q;
    assign subaddr  = mode_pins;

    // R9: in decoder-companion mode the register copies the detector a cycle later
    p_mpeg_tracks_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode == MODE_MPEG)) |-> (rate_reg == $past(det_code)))
        else $error("register did not follow detector");

    // R8: in standard mode the register changes only by a write
    p_std_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode == MODE_STANDARD) && !$past(wr_en)) |-> $stable(rate_reg))
        else $error("register changed without a write");

    // R7: decoder-companion mode always uses subaddress 3
    p_fixed_subaddr_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_MPEG) |-> (subaddr == 2'd3))
        else $error("wrong subaddress in companion mode");

endmodule

// File: rtl/srd_rate_detector.sv
module srd_rate_detector
    import srd_pkg::*;
#(
    parameter int REF_HZ   = 14_725_000,
    parameter int AVG_LOG2 = 10,
    parameter int PPM_TOL  = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ws_in,
    input  logic [1:0]        mode_pins,
    input  logic              reg_wr_en,
    input  logic [CODE_W-1:0] reg_wr_data,
    output logic [CODE_W-1:0] rate_code,
    output logic              rate_valid,
    output logic              rate_err,
    output logic [CODE_W-1:0] rate_reg,
    output logic [1:0]        bus_subaddr
);
    localparam int TO_LIM = 2 * ((REF_HZ + SLOWEST_HZ - 1) / SLOWEST_HZ);
    localparam int ACC_W  = $clog2((TO_LIM << AVG_LOG2) + 1);

    logic             meas_stb;
    logic             timeout_stb;
    logic [ACC_W-1:0] meas_cnt;
    class_res_t       cls;
    lock_state_t      lock;

    srd_period_meter #(.AVG_LOG2(AVG_LOG2), .TO_LIM(TO_LIM), .ACC_W(ACC_W)) u_meter (
        .clk(clk), .rst(rst), .ws_in(ws_in),
        .meas_stb(meas_stb), .meas_cnt(meas_cnt), .timeout_stb(timeout_stb)
    );

    srd_rate_classifier #(.REF_HZ(REF_HZ), .AVG_LOG2(AVG_LOG2), .PPM_TOL(PPM_TOL), .ACC_W(ACC_W)) u_class (
        .clk(clk), .rst(rst), .meas_cnt(meas_cnt), .result(cls)
    );

    srd_lock_tracker u_track (
        .clk(clk), .rst(rst), .meas_stb(meas_stb), .cls(cls),
        .timeout_stb(timeout_stb), .state(lock)
    );

    srd_rate_register u_reg (
        .clk(clk), .rst(rst), .mode_pins(mode_pins), .wr_en(reg_wr_en),
        .wr_data(reg_wr_data), .det_code(lock.code),
        .rate_reg(rate_reg), .subaddr(bus_subaddr)
    );

    assign rate_code  = lock.code;
    assign rate_valid = lock.valid;
    assign rate_err   = lock.err;

endmodule

// File: tb/srd_rate_detector_test.sv
module srd_rate_detector_test;
    localparam int REF_HZ   = 14_112_000;
    localparam int AVG_LOG2 = 2;
    localparam int NPER     = 4;
    localparam int TO_LIM   = 3528;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ws_in = 1'b0;
    logic [1:0] mode_pins = 2'd0;
    logic       reg_wr_en = 1'b0;
    logic [3:0] reg_wr_data = 4'd0;
    logic [3:0] rate_code;
    logic       rate_valid;
    logic       rate_err;
    logic [3:0] rate_reg;
    logic [1:0] bus_subaddr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    srd_rate_detector #(.REF_HZ(REF_HZ), .AVG_LOG2(AVG_LOG2), .PPM_TOL(200)) uut (
        .clk(clk), .rst(rst), .ws_in(ws_in), .mode_pins(mode_pins),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .rate_code(rate_code), .rate_valid(rate_valid), .rate_err(rate_err),
        .rate_reg(rate_reg), .bus_subaddr(bus_subaddr)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_lock(input string req, input int code, input bit valid, input bit err);
        check(req, "rate_code", 32'(rate_code), 32'(code));
        check(req, "rate_valid", 32'(rate_valid), 32'(valid));
        check(req, "rate_err", 32'(rate_err), 32'(err));
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int period_of(input int code);
        int hz;
        case (code)
            0: hz = 8000;   1: hz = 11025;  2: hz = 12000;
            3: hz = 16000;  4: hz = 22050;  5: hz = 24000;
            6: hz = 32000;  7: hz = 44100;  default: hz = 48000;
        endcase
        return REF_HZ / hz;
    endfunction

    // Rising edges are exactly p cycles apart; returns 12 cycles after the closing rise.
    task automatic ws_period(input int p);
        wait_cyc(p / 2 - 12);
        ws_in = 1'b0;
        wait_cyc(p - p / 2);
        ws_in = 1'b1;
        wait_cyc(12);
    endtask

    task automatic meas(input int p, input int extra);
        ws_period(p + extra);
        for (int i = 1; i < NPER; i++) ws_period(p);
    endtask

    // Silence past the timeout, then an opening rise: measurements align with later edges.
    task automatic resync();
        ws_in = 1'b0;
        wait_cyc(TO_LIM + 20);
        ws_in = 1'b1;
        wait_cyc(12);
    endtask

    task automatic write_reg(input logic [3:0] v);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        wait_cyc(1);
        reg_wr_en = 1'b0;
        wait_cyc(1);
    endtask

    task automatic test_reset();
        check_lock("R10", 0, 1'b0, 1'b0);
        check("R10", "rate_reg", 32'(rate_reg), 32'd15);
        check("R7", "subaddr after reset", 32'(bus_subaddr), 32'd0);
    endtask

    task automatic test_subaddr();
        for (int v = 1; v < 4; v++) begin
            mode_pins = 2'(v);
            wait_cyc(1);
            check("R7", "bus_subaddr", 32'(bus_subaddr), 32'(v));
        end
        mode_pins = 2'd0;
        wait_cyc(2);
    endtask

    task automatic test_std_write();
        write_reg(4'd3);
        check("R8", "written value", 32'(rate_reg), 32'd3);
        wait_cyc(5);
        check("R8", "value kept", 32'(rate_reg), 32'd3);
    endtask

    task automatic test_std_detect();
        resync();
        meas(period_of(8), 0);
        meas(period_of(8), 0);
        check_lock("R1", 8, 1'b1, 1'b0);
        check("R8", "register untouched by detection", 32'(rate_reg), 32'd3);
    endtask

    task automatic test_sweep();
        mode_pins = 2'd3;
        for (int c = 1; c < 9; c++) begin
            resync();
            meas(period_of(c), 0);
            check("R3", "valid after one measurement", 32'(rate_valid), 32'd0);
            meas(period_of(c), 0);
            check_lock("R1", c, 1'b1, 1'b0);
            check("R9", "register follows code", 32'(rate_reg), 32'(c));
        end
    endtask

    task automatic test_ppm();
        int p;
        p = period_of(0);
        resync();
        meas(p, 0);
        meas(p, 0);
        check_lock("R1", 0, 1'b1, 1'b0);
        meas(p, 1);      // about +142 ppm
        check_lock("R2", 0, 1'b1, 1'b0);
        meas(p, -1);     // about -142 ppm
        check_lock("R2", 0, 1'b1, 1'b0);
        meas(p, 2);      // about +283 ppm
        check_lock("R2", 0, 1'b0, 1'b1);
        meas(p, 0);
        check_lock("R3", 0, 1'b0, 1'b0);
        meas(p, 0);
        check_lock("R3", 0, 1'b1, 1'b0);
        meas(p, -2);     // about -283 ppm
        check_lock("R2", 0, 1'b0, 1'b1);
    endtask

    task automatic test_code_change();
        resync();
        meas(period_of(8), 0);
        meas(period_of(8), 0);
        check_lock("R3", 8, 1'b1, 1'b0);
        meas(period_of(7), 0);
        check_lock("R5", 8, 1'b0, 1'b0);
        meas(period_of(7), 0);
        check_lock("R5", 7, 1'b1, 1'b0);
    endtask

    task automatic test_out_of_window();
        meas(1000, 0);
        check_lock("R4", 7, 1'b0, 1'b1);
        meas(period_of(7), 0);
        check_lock("R4", 7, 1'b0, 1'b0);
    endtask

    task automatic test_timeout();
        meas(period_of(7), 0);
        check_lock("R3", 7, 1'b1, 1'b0);
        ws_in = 1'b0;
        wait_cyc(TO_LIM - 40);
        check("R6", "valid before timeout", 32'(rate_valid), 32'd1);
        wait_cyc(60);
        check_lock("R6", 7, 1'b0, 1'b0);
    endtask

    task automatic test_mpeg_write();
        write_reg(4'd5);
        check("R9", "write ignored", 32'(rate_reg), 32'd7);
        mode_pins = 2'd0;
        wait_cyc(2);
        check("R9", "kept on return to standard", 32'(rate_reg), 32'd7);
        check("R7", "subaddr standard", 32'(bus_subaddr), 32'd0);
        write_reg(4'd2);
        check("R8", "write in standard", 32'(rate_reg), 32'd2);
    endtask

    initial begin : watchdog
        repeat (190_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        test_reset();
        test_subaddr();
        test_std_write();
        test_std_detect();
        test_sweep();
        test_ppm();
        test_code_change();
        test_out_of_window();
        test_timeout();
        test_mpeg_write();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule